// File: doc/BRIEF.md
# Two-Level Translation Lookaside Sequencer

This block turns a virtual address into a physical address for one memory access at a time. It searches a small, fully associative first-level store, then a larger second-level store. If both miss, it asks an external page-table walker for the mapping. Each stored mapping carries a virtual page number, a page size, a physical page number, an address-space tag or a global flag, a security-world flag, access-permission bits, a domain number and memory attributes. An entry is used only when all of the following hold:

- its world flag equals the request's world;
- it is global, or its address-space tag equals the request's;
- the virtual address bits above the entry's page size are equal.

Requests enter on a valid/ready channel. The sequencer accepts a new request only while it is idle. The requester may hold `req_valid` for as long as it likes, and the request is taken on the first cycle with both signals high. The result leaves on a second valid/ready channel. It stays stable until the consumer raises `rsp_ready`, so back-pressure there stalls the whole block. The walk request is also valid/ready and is held stable until the walker accepts it. The walker then returns exactly one response pulse on `wrsp_valid`. A pulse at any other time is ignored.

Two walk-disable bits, a split boundary and a table of domain access controls are plain static inputs. A lookup that the walk-disable logic blocks ends in a translation fault, and no walk is started.

Top module: `tlb_seq`

## Requirements
- R1: A request that hits the first-level store puts `rsp_valid` high on the second rising edge after the accepting edge, and no walk is requested.
- R2: The second-level store is searched only after a first-level miss. A hit there responds on the third edge after acceptance, with no walk, and copies the entry into the first level so that the next access to that page hits on the second edge.
- R3: A miss in both levels, with walks allowed, raises `walk_valid` carrying the request's address, address-space tag and world flag. These are held stable until `walk_ready`.
- R4: Walk disable is chosen by the top `SPLIT_W` address bits. A value below `split_top` uses `walk_dis[0]`, and any other value (including equality) uses `walk_dis[1]`. A miss with the chosen bit set returns fault 01 on the third edge without a walk. Hits are unaffected.
- R5: A good walk response fills both levels, so the same page then hits without a walk. A response with `wrsp_err` set returns fault 01 and fills nothing.
- R6: An entry matches only when its world flag equals the request's, it is global or its tag equals the request tag, and the virtual bits above its page size agree. Size codes 0/1/2/3 mean 4 KiB, 64 KiB, 1 MiB and 16 MiB. The physical address takes the entry's page-number bits above the size and the virtual bits below.
- R7: The fault code is 00 none, 01 translation, 10 permission, 11 domain. For a client domain, the access bits decide as follows:
  - 00 denies all accesses;
  - 01 allows privileged accesses only;
  - 10 allows privileged accesses and unprivileged reads;
  - 11 allows everything.
  A denied access gives fault 10.
- R8: Domain d reads `dom_ctl[2d+1:2d]`. A value of 00 or 10 gives fault 11. A value of 11 (manager) allows the access whatever the access bits are. A value of 01 (client) applies R7.
- R9: Once `rsp_valid` is high it stays high, with `rsp_pa`, `rsp_attr` and `rsp_fault` stable, until `rsp_ready`. `req_ready` stays low from acceptance until the response is taken. On any fault, `rsp_pa` and `rsp_attr` are zero.
- R10: Reset empties both stores and leaves `req_ready` high with `rsp_valid` and `walk_valid` low.
- R11: The first level holds `UTLB_N` entries and replaces them in fill order, the oldest fill first. An evicted page that is still in the second level is found there, on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space tag |
| req_ns | input | 1 | Non-secure world flag |
| req_write | input | 1 | Access is a write |
| req_priv | input | 1 | Access is privileged |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_attr | output | 4 | Memory attributes (zero on fault) |
| rsp_fault | output | 2 | Fault code per R7 |
| walk_valid | output | 1 | Walk request offered |
| walk_ready | input | 1 | Walker takes the request |
| walk_va | output | 32 | Address to walk |
| walk_asid | output | 8 | Address-space tag to walk |
| walk_ns | output | 1 | World flag to walk |
| wrsp_valid | input | 1 | Walk result pulse |
| wrsp_err | input | 1 | Walk found no valid mapping |
| wrsp_ppn | input | 20 | Physical page number |
| wrsp_size | input | 2 | Page size code |
| wrsp_global | input | 1 | Mapping is global |
| wrsp_ap | input | 2 | Access bits |
| wrsp_dom | input | 4 | Domain number |
| wrsp_attr | input | 4 | Memory attributes |
| walk_dis | input | 2 | Walk disable for lower and upper address halves |
| split_top | input | 3 | Split boundary on the top address bits |
| dom_ctl | input | 32 | Two control bits per domain |

## Verification
A bad replacement pointer or a fill that goes to the wrong level appears only as latency. The response arrives on the third edge instead of the second, or a walk appears where a hit was due. The bench therefore counts edges from acceptance to `rsp_valid` for every hit and records every walk request. A fill after a walker error, or a mismatch on world flag or address-space tag, shows at the ports at the next access to that page, as a missing or unexpected walk. A wrong permission or domain decode shows immediately in `rsp_fault` and in the zeroed address.

// File: rtl/tlb_seq_pkg.sv
package tlb_seq_pkg;
  parameter int VA_W     = 32;
  parameter int PG_SHIFT = 12;
  parameter int VPN_W    = VA_W - PG_SHIFT;
  parameter int ASID_W   = 8;
  parameter int DOM_W    = 4;
  parameter int NUM_DOM  = 1 << DOM_W;
  parameter int ATTR_W   = 4;
  parameter int SZ_STEP  = 4;   // page-number bits dropped per size code step

  typedef enum logic [1:0] {SZ_4K, SZ_64K, SZ_1M, SZ_16M} pg_size_e;
  typedef enum logic [1:0] {FLT_NONE, FLT_XLATE, FLT_PERM, FLT_DOM} fault_e;
  typedef enum logic [2:0] {ST_IDLE, ST_MICRO, ST_MAIN, ST_WALK, ST_RESP} seq_state_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    pg_size_e          size;
    logic              global;
    logic [ASID_W-1:0] asid;
    logic              ns;
    logic [1:0]        ap;
    logic [DOM_W-1:0]  dom;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;

  function automatic logic [VPN_W-1:0] size_mask(pg_size_e s);
    return ~((VPN_W'(1) << (int'(s) * SZ_STEP)) - VPN_W'(1));
  endfunction

  function automatic logic [VA_W-1:0] compose_pa(tlb_entry_t e, logic [VA_W-1:0] va);
    logic [VPN_W-1:0] m;
    m = size_mask(e.size);
    return {(e.ppn & m) | (va[VA_W-1:PG_SHIFT] & ~m), va[PG_SHIFT-1:0]};
  endfunction
endpackage

// File: rtl/tlb_seq_array.sv
module tlb_seq_array
  import tlb_seq_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic              key_ns,
  output logic              hit,
  output tlb_entry_t        hit_ent,
  input  logic              fill_en,
  input  tlb_entry_t        fill_ent
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
  localparam int ENT_W = $bits(tlb_entry_t);

  tlb_entry_t       ent_q [N];
  logic [N-1:0]     match;
  logic [PTR_W-1:0] vic_q;
  logic [ENT_W-1:0] acc;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = ent_q[i].valid
                   && (ent_q[i].ns == key_ns)
                   && (ent_q[i].global || (ent_q[i].asid == key_asid))
                   && (((ent_q[i].vpn ^ key_vpn) & size_mask(ent_q[i].size)) == '0);
  end

  // software keeps matches unique, so an OR of the hitting entries selects one
  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) acc = acc | ENT_W'(ent_q[i]);
    end
  end

  assign hit     = |match;
  assign hit_ent = tlb_entry_t'(acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
      vic_q <= '0;
    end else if (fill_en) begin
      ent_q[vic_q] <= fill_ent;
      vic_q <= (vic_q == PTR_W'(N - 1)) ? '0 : vic_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_seq_perm.sv
module tlb_seq_perm
  import tlb_seq_pkg::*;
(
  input  logic [1:0]           ap,
  input  logic [DOM_W-1:0]     dom,
  input  logic [2*NUM_DOM-1:0] dom_ctl,
  input  logic                 wr,
  input  logic                 priv,
  output fault_e               fault
);
  logic [1:0] dacc;
  logic       ap_ok;

  assign dacc = dom_ctl[{dom, 1'b0} +: 2];

  always_comb begin
    case (ap)
      2'b00:   ap_ok = 1'b0;
      2'b01:   ap_ok = priv;
      2'b10:   ap_ok = priv || !wr;
      default: ap_ok = 1'b1;
    endcase
  end

  always_comb begin
    case (dacc)
      2'b11:   fault = FLT_NONE;
      2'b01:   fault = ap_ok ? FLT_NONE : FLT_PERM;
      default: fault = FLT_DOM;
    endcase
  end
endmodule

// File: rtl/tlb_seq.sv
module tlb_seq
  import tlb_seq_pkg::*;
#(
  parameter int UTLB_N  = 4,
  parameter int MTLB_N  = 16,
  parameter int SPLIT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_va,
  input  logic [ASID_W-1:0]    req_asid,
  input  logic                 req_ns,
  input  logic                 req_write,
  input  logic                 req_priv,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [VA_W-1:0]      rsp_pa,
  output logic [ATTR_W-1:0]    rsp_attr,
  output logic [1:0]           rsp_fault,
  output logic                 walk_valid,
  input  logic                 walk_ready,
  output logic [VA_W-1:0]      walk_va,
  output logic [ASID_W-1:0]    walk_asid,
  output logic                 walk_ns,
  input  logic                 wrsp_valid,
  input  logic                 wrsp_err,
  input  logic [VPN_W-1:0]     wrsp_ppn,
  input  logic [1:0]           wrsp_size,
  input  logic                 wrsp_global,
  input  logic [1:0]           wrsp_ap,
  input  logic [DOM_W-1:0]     wrsp_dom,
  input  logic [ATTR_W-1:0]    wrsp_attr,
  input  logic [1:0]           walk_dis,
  input  logic [SPLIT_W-1:0]   split_top,
  input  logic [2*NUM_DOM-1:0] dom_ctl
);
  seq_state_e        st_q;
  logic [VA_W-1:0]   rq_va;
  logic [ASID_W-1:0] rq_asid;
  logic              rq_ns, rq_wr, rq_priv;
  logic              wsent_q;
  logic [VA_W-1:0]   rsp_pa_q;
  logic [ATTR_W-1:0] rsp_attr_q;
  fault_e            rsp_flt_q;

  logic       u_hit, m_hit;
  tlb_entry_t u_ent, m_ent, walk_ent, chk_ent, u_fill_ent;
  logic       u_fill, m_fill;
  logic       walk_done, walk_done_ok, walk_off;
  fault_e     chk_flt;
  logic [VA_W-1:0]   res_pa;
  logic [ATTR_W-1:0] res_attr;

  tlb_seq_array #(.N(UTLB_N)) u_micro (
    .clk(clk), .rst_n(rst_n),
    .key_vpn(rq_va[VA_W-1:PG_SHIFT]), .key_asid(rq_asid), .key_ns(rq_ns),
    .hit(u_hit), .hit_ent(u_ent),
    .fill_en(u_fill), .fill_ent(u_fill_ent)
  );

  tlb_seq_array #(.N(MTLB_N)) u_main (
    .clk(clk), .rst_n(rst_n),
    .key_vpn(rq_va[VA_W-1:PG_SHIFT]), .key_asid(rq_asid), .key_ns(rq_ns),
    .hit(m_hit), .hit_ent(m_ent),
    .fill_en(m_fill), .fill_ent(walk_ent)
  );

  always_comb begin
    walk_ent        = '0;
    walk_ent.valid  = 1'b1;
    walk_ent.vpn    = rq_va[VA_W-1:PG_SHIFT];
    walk_ent.ppn    = wrsp_ppn;
    walk_ent.size   = pg_size_e'(wrsp_size);
    walk_ent.global = wrsp_global;
    walk_ent.asid   = rq_asid;
    walk_ent.ns     = rq_ns;
    walk_ent.ap     = wrsp_ap;
    walk_ent.dom    = wrsp_dom;
    walk_ent.attr   = wrsp_attr;
  end

  always_comb begin
    if (st_q == ST_MICRO)     chk_ent = u_ent;
    else if (st_q == ST_MAIN) chk_ent = m_ent;
    else                      chk_ent = walk_ent;
  end

  tlb_seq_perm u_perm (
    .ap(chk_ent.ap), .dom(chk_ent.dom), .dom_ctl(dom_ctl),
    .wr(rq_wr), .priv(rq_priv), .fault(chk_flt)
  );

  assign res_pa   = (chk_flt == FLT_NONE) ? compose_pa(chk_ent, rq_va) : '0;
  assign res_attr = (chk_flt == FLT_NONE) ? chk_ent.attr : '0;

  assign walk_off     = (rq_va[VA_W-1 -: SPLIT_W] < split_top) ? walk_dis[0] : walk_dis[1];
  assign walk_done    = (st_q == ST_WALK) && wsent_q && wrsp_valid;
  assign walk_done_ok = walk_done && !wrsp_err;
  assign u_fill       = ((st_q == ST_MAIN) && m_hit) || walk_done_ok;
  assign u_fill_ent   = (st_q == ST_MAIN) ? m_ent : walk_ent;
  assign m_fill       = walk_done_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      rq_va      <= '0;
      rq_asid    <= '0;
      rq_ns      <= 1'b0;
      rq_wr      <= 1'b0;
      rq_priv    <= 1'b0;
      wsent_q    <= 1'b0;
      rsp_pa_q   <= '0;
      rsp_attr_q <= '0;
      rsp_flt_q  <= FLT_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          rq_va   <= req_va;
          rq_asid <= req_asid;
          rq_ns   <= req_ns;
          rq_wr   <= req_write;
          rq_priv <= req_priv;
          st_q    <= ST_MICRO;
        end
        ST_MICRO: begin
          if (u_hit) begin
            rsp_flt_q  <= chk_flt;
            rsp_pa_q   <= res_pa;
            rsp_attr_q <= res_attr;
            st_q       <= ST_RESP;
          end else begin
            st_q <= ST_MAIN;
          end
        end
        ST_MAIN: begin
          if (m_hit) begin
            rsp_flt_q  <= chk_flt;
            rsp_pa_q   <= res_pa;
            rsp_attr_q <= res_attr;
            st_q       <= ST_RESP;
          end else if (walk_off) begin
            rsp_flt_q  <= FLT_XLATE;
            rsp_pa_q   <= '0;
            rsp_attr_q <= '0;
            st_q       <= ST_RESP;
          end else begin
            wsent_q <= 1'b0;
            st_q    <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (walk_valid && walk_ready) wsent_q <= 1'b1;
          if (walk_done) begin
            st_q <= ST_RESP;
            if (wrsp_err) begin
              rsp_flt_q  <= FLT_XLATE;
              rsp_pa_q   <= '0;
              rsp_attr_q <= '0;
            end else begin
              rsp_flt_q  <= chk_flt;
              rsp_pa_q   <= res_pa;
              rsp_attr_q <= res_attr;
            end
          end
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign rsp_valid  = (st_q == ST_RESP);
  assign rsp_pa     = rsp_pa_q;
  assign rsp_attr   = rsp_attr_q;
  assign rsp_fault  = rsp_flt_q;
  assign walk_valid = (st_q == ST_WALK) && !wsent_q;
  assign walk_va    = rq_va;
  assign walk_asid  = rq_asid;
  assign walk_ns    = rq_ns;
endmodule

// File: rtl/tlb_seq_chk.sv
module tlb_seq_chk
  import tlb_seq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [VA_W-1:0] rsp_pa,
  input logic [1:0]      rsp_fault,
  input logic            walk_valid,
  input logic            walk_ready,
  input logic [VA_W-1:0] walk_va,
  input logic            wrsp_valid,
  input logic            wrsp_err,
  input seq_state_e      st_q,
  input logic            u_hit,
  input logic            m_hit,
  input logic            walk_off,
  input logic            wsent_q
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid && !walk_ready |=> walk_valid && $stable(walk_va)); // R3
  AST_WALK_ONLY_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid |-> st_q == ST_WALK); // R3
  AST_MICRO_HIT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_MICRO && u_hit |=> rsp_valid && !walk_valid); // R1
  AST_MAIN_HIT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_MAIN && m_hit |=> rsp_valid && rsp_fault != 2'b01); // R2
  AST_WALK_OFF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_MAIN && !m_hit && walk_off |=> rsp_valid && rsp_fault == 2'b01 && !walk_valid); // R4
  AST_WALK_ERR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_WALK && wsent_q && wrsp_valid && wrsp_err |=> rsp_valid && rsp_fault == 2'b01); // R5
endmodule

bind tlb_seq tlb_seq_chk u_tlb_seq_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
  .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_va(walk_va),
  .wrsp_valid(wrsp_valid), .wrsp_err(wrsp_err), .st_q(st_q),
  .u_hit(u_hit), .m_hit(m_hit), .walk_off(walk_off), .wsent_q(wsent_q)
);

// File: tb/tlb_seq_bench.sv
`timescale 1ns/1ps
module tlb_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_ready, req_ns = 0, req_write = 0, req_priv = 0;
  logic [31:0] req_va = 0;
  logic [7:0]  req_asid = 0;
  logic        rsp_valid, rsp_ready = 0;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_attr;
  logic [1:0]  rsp_fault;
  logic        walk_valid, walk_ready = 0, walk_ns;
  logic [31:0] walk_va;
  logic [7:0]  walk_asid;
  logic        wrsp_valid = 0, wrsp_err = 0, wrsp_global = 0;
  logic [19:0] wrsp_ppn = 0;
  logic [1:0]  wrsp_size = 0, wrsp_ap = 0;
  logic [3:0]  wrsp_dom = 0, wrsp_attr = 0;
  logic [1:0]  walk_dis = 0;
  logic [2:0]  split_top = 3'b100;
  logic [31:0] dom_ctl = 32'h5555_5715; // d3 no access, d4 manager, rest client

  tlb_seq u_tlb_seq (.*);

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [31:0] va; logic [7:0] asid; logic ns, wr, pv; logic [1:0] kind;
    logic werr; logic [19:0] wppn; logic [1:0] wsz; logic wglb; logic [1:0] wap;
    logic [3:0] wdom, wattr; logic [1:0] efl; logic [31:0] epa; logic [3:0] eattr;
  } vec_t;

  // kind: 0 first-level hit, 1 second-level hit, 2 walk
  localparam vec_t VEC [19] = '{
    '{32'h00001234,8'd5,1'b0,1'b0,1'b0,2'd2,1'b0,20'h80001,2'd0,1'b0,2'd3,4'd0,4'h3,2'd0,32'h80001234,4'h3}, // R3 R5
    '{32'h00001ABC,8'd5,1'b0,1'b0,1'b0,2'd0,1'b0,20'h0,2'd0,1'b0,2'd0,4'd0,4'h0,2'd0,32'h80001ABC,4'h3},    // R1 R5
    '{32'h00001ABC,8'd6,1'b0,1'b0,1'b0,2'd2,1'b0,20'h90001,2'd0,1'b0,2'd3,4'd0,4'h4,2'd0,32'h90001ABC,4'h4}, // R6 asid
    '{32'h00001ABC,8'd5,1'b1,1'b0,1'b0,2'd2,1'b1,20'hA0001,2'd0,1'b0,2'd3,4'd0,4'h5,2'd1,32'h0,4'h0},        // R6 world, R5 err
    '{32'h00001ABC,8'd5,1'b1,1'b0,1'b0,2'd2,1'b0,20'hA0001,2'd0,1'b0,2'd3,4'd0,4'h5,2'd0,32'hA0001ABC,4'h5}, // R5 no fill on err
    '{32'h00312345,8'd1,1'b0,1'b0,1'b0,2'd2,1'b0,20'hC0100,2'd2,1'b1,2'd3,4'd0,4'h6,2'd0,32'hC0112345,4'h6}, // R6 1MiB
    '{32'h003FFFF0,8'd9,1'b0,1'b0,1'b0,2'd0,1'b0,20'h0,2'd0,1'b0,2'd0,4'd0,4'h0,2'd0,32'hC01FFFF0,4'h6},    // R6 global
    '{32'h05000040,8'd2,1'b0,1'b0,1'b0,2'd2,1'b0,20'hD0000,2'd3,1'b0,2'd3,4'd0,4'h7,2'd0,32'hD0000040,4'h7}, // R6 16MiB
    '{32'h00001FFC,8'd5,1'b0,1'b0,1'b0,2'd1,1'b0,20'h0,2'd0,1'b0,2'd0,4'd0,4'h0,2'd0,32'h80001FFC,4'h3},    // R11 evicted, R2
    '{32'h00123456,8'd5,1'b0,1'b1,1'b0,2'd2,1'b0,20'h70020,2'd1,1'b0,2'd3,4'd0,4'h8,2'd0,32'h70023456,4'h8}, // R6 64KiB
    '{32'h00002000,8'd5,1'b0,1'b1,1'b0,2'd2,1'b0,20'h60002,2'd0,1'b0,2'd2,4'd0,4'h9,2'd2,32'h0,4'h0},        // R7 user write ap10
    '{32'h00002000,8'd5,1'b0,1'b0,1'b0,2'd0,1'b0,20'h0,2'd0,1'b0,2'd0,4'd0,4'h0,2'd0,32'h60002000,4'h9},    // R7 user read ap10
    '{32'h00002004,8'd5,1'b0,1'b1,1'b1,2'd0,1'b0,20'h0,2'd0,1'b0,2'd0,4'd0,4'h0,2'd0,32'h60002004,4'h9},    // R7 priv write ap10
    '{32'h00003000,8'd5,1'b0,1'b0,1'b0,2'd2,1'b0,20'h60003,2'd0,1'b0,2'd1,4'd0,4'hA,2'd2,32'h0,4'h0},        // R7 user ap01
    '{32'h00004000,8'd5,1'b0,1'b0,1'b1,2'd2,1'b0,20'h60004,2'd0,1'b0,2'd3,4'd3,4'hB,2'd3,32'h0,4'h0},        // R8 no access
    '{32'h00005000,8'd5,1'b0,1'b1,1'b0,2'd2,1'b0,20'h50005,2'd0,1'b0,2'd0,4'd4,4'hC,2'd0,32'h50005000,4'hC}, // R8 manager
    '{32'h00006000,8'd5,1'b0,1'b0,1'b1,2'd2,1'b0,20'h60006,2'd0,1'b0,2'd0,4'd0,4'hD,2'd2,32'h0,4'h0},        // R7 ap00
    '{32'h00003000,8'd5,1'b0,1'b0,1'b1,2'd0,1'b0,20'h0,2'd0,1'b0,2'd0,4'd0,4'h0,2'd0,32'h60003000,4'hA},    // R7 priv ap01, R11 kept
    '{32'h05ABCDEF,8'd2,1'b0,1'b0,1'b0,2'd1,1'b0,20'h0,2'd0,1'b0,2'd0,4'd0,4'h0,2'd0,32'hD0ABCDEF,4'h7}     // R2 R11
  };

  task automatic run_req(input vec_t v, input int hold,
                         output int lat, output bit walked,
                         output logic [1:0] flt, output logic [31:0] pa, output logic [3:0] attr);
    logic [31:0] p0;
    walked = 0;
    @(negedge clk);
    req_valid = 1; req_va = v.va; req_asid = v.asid; req_ns = v.ns;
    req_write = v.wr; req_priv = v.pv;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    forever begin
      if (wrsp_valid) wrsp_valid = 0;
      if (rsp_valid) break;
      if (walk_ready) begin
        walk_ready = 0;
        wrsp_valid = 1; wrsp_err = v.werr; wrsp_ppn = v.wppn; wrsp_size = v.wsz;
        wrsp_global = v.wglb; wrsp_ap = v.wap; wrsp_dom = v.wdom; wrsp_attr = v.wattr;
      end else if (walk_valid) begin
        walk_ready = 1; walked = 1;
        check(walk_va == v.va && walk_asid == v.asid && walk_ns == v.ns, "R3 walk fields", walk_va, v.va);
      end
      @(negedge clk);
      lat++;
      if (lat > 60) begin
        check(0, "R9 response timeout", 32'(lat), 32'd60);
        break;
      end
    end
    flt = rsp_fault; pa = rsp_pa; attr = rsp_attr;
    p0 = rsp_pa;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid && !req_ready && rsp_pa == p0, "R9 hold under back-pressure", {rsp_valid, req_ready, 30'd0}, 32'h8000_0000);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic expect_res(input vec_t v, input int lat, input bit walked,
                            input logic [1:0] flt, input logic [31:0] pa, input logic [3:0] attr);
    check(walked == (v.kind == 2'd2), "R1 R2 R3 walk presence", 32'(walked), 32'(v.kind == 2'd2));
    if (v.kind == 2'd0) check(lat == 2, "R1 first-level latency", 32'(lat), 32'd2);
    if (v.kind == 2'd1) check(lat == 3, "R2 second-level latency", 32'(lat), 32'd3);
    check(flt == v.efl, "R7 R8 fault code", 32'(flt), 32'(v.efl));
    check(pa == v.epa, "R6 physical address", pa, v.epa);
    check(attr == v.eattr, "R6 R9 attributes", 32'(attr), 32'(v.eattr));
  endtask

  function automatic vec_t mk(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind,
                              input logic [19:0] ppn, input logic [1:0] efl, input logic [31:0] epa, input logic [3:0] eattr);
    vec_t v = '0;
    v.va = va; v.asid = asid; v.kind = kind; v.wppn = ppn; v.wap = 2'd3;
    v.wattr = 4'h1; v.efl = efl; v.epa = epa; v.eattr = eattr;
    return v;
  endfunction

  initial begin
    int lat; bit walked; logic [1:0] flt; logic [31:0] pa; logic [3:0] attr;
    vec_t v;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(req_ready && !rsp_valid && !walk_valid, "R10 reset outputs", {req_ready, rsp_valid, walk_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !walk_valid, "R10 idle after reset", {req_ready, rsp_valid, walk_valid}, 3'b100);

    foreach (VEC[i]) begin
      run_req(VEC[i], 0, lat, walked, flt, pa, attr);
      expect_res(VEC[i], lat, walked, flt, pa, attr);
    end

    // R4: lower half disabled, miss faults with no walk on the third edge
    walk_dis = 2'b01;
    v = mk(32'h00007000, 8'd5, 2'd1, 20'h0, 2'd1, 32'h0, 4'h0);
    run_req(v, 0, lat, walked, flt, pa, attr);
    expect_res(v, lat, walked, flt, pa, attr);
    // R4: upper half still walks
    v = mk(32'hA0000000, 8'd5, 2'd2, 20'h12345, 2'd0, 32'h12345000, 4'h1);
    run_req(v, 0, lat, walked, flt, pa, attr);
    expect_res(v, lat, walked, flt, pa, attr);
    // R4: boundary value equal to split_top selects upper bit
    walk_dis = 2'b10;
    v = mk(32'h80000000, 8'd5, 2'd1, 20'h0, 2'd1, 32'h0, 4'h0);
    run_req(v, 0, lat, walked, flt, pa, attr);
    expect_res(v, lat, walked, flt, pa, attr);
    v = mk(32'h40000000, 8'd5, 2'd2, 20'h44444, 2'd0, 32'h44444000, 4'h1);
    run_req(v, 0, lat, walked, flt, pa, attr);
    expect_res(v, lat, walked, flt, pa, attr);
    // R4: both disabled, second-level hit still translates
    walk_dis = 2'b11;
    v = mk(32'h00001000, 8'd5, 2'd1, 20'h0, 2'd0, 32'h80001000, 4'h3);
    run_req(v, 0, lat, walked, flt, pa, attr);
    expect_res(v, lat, walked, flt, pa, attr);
    // R9: back-pressure on a first-level hit (refilled just above, R2)
    v = mk(32'h00001004, 8'd5, 2'd0, 20'h0, 2'd0, 32'h80001004, 4'h3);
    run_req(v, 3, lat, walked, flt, pa, attr);
    expect_res(v, lat, walked, flt, pa, attr);

    // R10: reset empties both stores, the page walks again
    walk_dis = 2'b00;
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk);
    check(req_ready && !rsp_valid && !walk_valid, "R10 reset mid-run", {req_ready, rsp_valid, walk_valid}, 3'b100);
    rst_n = 1;
    v = mk(32'h00001234, 8'd5, 2'd2, 20'h81001, 2'd0, 32'h81001234, 4'h1);
    run_req(v, 0, lat, walked, flt, pa, attr);
    expect_res(v, lat, walked, flt, pa, attr);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule